// File: doc/BRIEF.md
# Ten-Bit Slave Address Match Tracker

This block sits in the address path of a two-wire serial slave and decides when a 10-bit slave address has been matched. The byte shifter in front of it delivers each completed byte as a one-cycle strobe. Each byte is tagged to say whether it is the first byte after a Start or a repeated Start. Separate one-cycle pulses mark Start, repeated Start and Stop. The block compares the leading address byte, which carries the two upper address bits and the direction bit, with the programmed address. It then compares the trailing address byte with the lower eight address bits.

A full match with the write direction grants write access and stores a remembered-match bit. Reading from the slave is a two-step process. The master first completes a full write-direction match, then issues a repeated Start and sends only the leading byte with the direction bit set. That read is acknowledged only while the remembered-match bit is set. When the read is granted, the block also raises a clock-stretch request. The request stays up until the transmit data is loaded or an explicit release arrives, which gives the data path time to prepare the byte.

Top module: `addr10_tracker`

## Requirements
- R1: During and after reset, `addr_ack`, `wr_sel`, `rd_sel` and `hold_req` are 0, and the remembered-match bit is clear.
- R2: A byte with `byte_first`=1 is a leading address byte with layout {1,1,1,1,0,A9,A8,DIR}, where bit 0 is DIR. It is acknowledged only if bits 7:3 equal 11110 and bits 2:1 equal `own_addr[9:8]`. Any other leading byte is never acknowledged.
- R3: A matching leading byte with DIR=0 produces a one-cycle `addr_ack` in the cycle after the byte strobe. The block then expects a trailing address byte.
- R4: The trailing byte (`byte_first`=0, right after an acknowledged DIR=0 leading byte) is compared with `own_addr[7:0]`. If it is equal, `addr_ack` pulses, `wr_sel` rises and the remembered-match bit is set. If it differs, there is no acknowledge and no select.
- R5: A Stop clears the remembered-match bit, `wr_sel` and `rd_sel`.
- R6: A leading byte clears the remembered-match bit if it does not match, or if it matches with DIR=0. A matching leading byte with DIR=1 leaves the bit unchanged.
- R7: A matching leading byte with DIR=1 is acknowledged only while the remembered-match bit is set. When it is acknowledged, `rd_sel` and `hold_req` rise one cycle after the strobe. Without the remembered-match bit there is no acknowledge, no `rd_sel` and no `hold_req`.
- R8: Once raised, `hold_req` stays high until a `tx_loaded` or `hold_release` pulse. It falls in the cycle after that pulse, and `rd_sel` is not affected by this.
- R9: A Start or repeated Start clears `wr_sel` and `rd_sel` but keeps the remembered-match bit. A Start or Stop pulse takes priority over a byte strobe in the same cycle, and that byte is ignored.
- R10: A byte with `byte_first`=0 that arrives while no trailing address byte is expected is ignored. It produces no acknowledge and changes no select or hold state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | 10 | Programmed slave address |
| start_pulse | input | 1 | Start or repeated Start seen (one cycle) |
| stop_pulse | input | 1 | Stop seen (one cycle) |
| byte_valid | input | 1 | Completed byte strobe |
| byte_first | input | 1 | Byte is the first after a Start or repeated Start |
| byte_data | input | 8 | Completed byte |
| tx_loaded | input | 1 | Transmit data written, ends clock stretch |
| hold_release | input | 1 | Explicit clock-stretch release |
| addr_ack | output | 1 | Address byte acknowledged (one-cycle pulse) |
| wr_sel | output | 1 | Slave selected for writing |
| rd_sel | output | 1 | Slave selected for reading |
| hold_req | output | 1 | Request to hold the serial clock low |

## Verification
Every result is registered. The acknowledge, the selects and the hold request therefore change exactly one clock edge after the strobe or pulse that causes them. The bench drives each input for a single cycle starting on a falling edge. It removes the input on the next falling edge and checks the outputs at that point, just after the one edge that captured the input. The remembered-match bit has no port of its own, so the bench reads it through a probe: a repeated Start followed by a DIR=1 leading byte, where the acknowledge reports the bit one cycle after the probe byte. Sweeps cover all 256 leading-byte values and all 256 trailing-byte values for four programmed addresses.

// File: rtl/a10_pkg.sv
package a10_pkg;

    localparam int ADDR_BITS   = 10;
    localparam int BYTE_BITS   = 8;
    localparam int UPPER_BITS  = ADDR_BITS - BYTE_BITS;
    localparam int PREFIX_BITS = BYTE_BITS - UPPER_BITS - 1;
    localparam logic [PREFIX_BITS-1:0] HI_PREFIX = 5'b11110;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HI,
        PH_LO,
        PH_DATA
    } phase_t;

    typedef struct packed {
        logic fmt_ok;
        logic upper_eq;
        logic dir_rd;
    } hi_info_t;

    function automatic hi_info_t decode_hi(
        input logic [BYTE_BITS-1:0]  b,
        input logic [UPPER_BITS-1:0] upper
    );
        hi_info_t r;
        r.fmt_ok   = (b[BYTE_BITS-1 -: PREFIX_BITS] == HI_PREFIX);
        r.upper_eq = (b[UPPER_BITS:1] == upper);
        r.dir_rd   = b[0];
        return r;
    endfunction

endpackage

// File: rtl/a10_hi_decode.sv
module a10_hi_decode
    import a10_pkg::*;
(
    input  logic [BYTE_BITS-1:0]  byte_data,
    input  logic [UPPER_BITS-1:0] own_upper,
    output hi_info_t              info
);

    always_comb begin
        info = decode_hi(byte_data, own_upper);
    end

endmodule

// File: rtl/a10_lo_compare.sv
module a10_lo_compare
    import a10_pkg::*;
(
    input  logic [BYTE_BITS-1:0] byte_data,
    input  logic [BYTE_BITS-1:0] own_lower,
    output logic                 lo_eq
);

    always_comb begin
        lo_eq = (byte_data == own_lower);
    end

endmodule

// File: rtl/a10_match_ctrl.sv
module a10_match_ctrl
    import a10_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_pulse,
    input  logic     stop_pulse,
    input  logic     byte_valid,
    input  logic     byte_first,
    input  hi_info_t hi,
    input  logic     lo_eq,
    output logic     addr_ack,
    output logic     wr_sel,
    output logic     rd_sel,
    output logic     read_grant
);

    phase_t phase_q, phase_n;
    logic   prior_q, prior_n;
    logic   wr_n, rd_n, ack_n;
    logic   hi_match;

    assign hi_match = hi.fmt_ok && hi.upper_eq;

    always_comb begin
        phase_n    = phase_q;
        prior_n    = prior_q;
        wr_n       = wr_sel;
        rd_n       = rd_sel;
        ack_n      = 1'b0;
        read_grant = 1'b0;
        if (stop_pulse) begin
            phase_n = PH_IDLE;
            prior_n = 1'b0;
            wr_n    = 1'b0;
            rd_n    = 1'b0;
        end else if (start_pulse) begin
            phase_n = PH_HI;
            wr_n    = 1'b0;
            rd_n    = 1'b0;
        end else if (byte_valid && byte_first) begin
            wr_n = 1'b0;
            rd_n = 1'b0;
            if (!hi_match) begin
                prior_n = 1'b0;
                phase_n = PH_IDLE;
            end else if (!hi.dir_rd) begin
                prior_n = 1'b0;
                ack_n   = 1'b1;
                phase_n = PH_LO;
            end else if (prior_q) begin
                ack_n      = 1'b1;
                rd_n       = 1'b1;
                read_grant = 1'b1;
                phase_n    = PH_DATA;
            end else begin
                phase_n = PH_IDLE;
            end
        end else if (byte_valid && phase_q == PH_LO) begin
            if (lo_eq) begin
                ack_n   = 1'b1;
                wr_n    = 1'b1;
                prior_n = 1'b1;
                phase_n = PH_DATA;
            end else begin
                phase_n = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            prior_q  <= 1'b0;
            wr_sel   <= 1'b0;
            rd_sel   <= 1'b0;
            addr_ack <= 1'b0;
        end else begin
            phase_q  <= phase_n;
            prior_q  <= prior_n;
            wr_sel   <= wr_n;
            rd_sel   <= rd_n;
            addr_ack <= ack_n;
        end
    end

    AST_ACK_FROM_BYTE: assert property (@(posedge clk) disable iff (rst)
        addr_ack |-> $past(byte_valid)); // R3
    AST_READ_NEEDS_PRIOR: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_sel) |-> $past(prior_q)); // R7
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |=> (!prior_q && !wr_sel && !rd_sel)); // R5
    AST_PRIOR_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(prior_q) |-> wr_sel); // R4
    AST_START_KEEPS_PRIOR: assert property (@(posedge clk) disable iff (rst)
        (start_pulse && !stop_pulse) |=> (prior_q == $past(prior_q) && !wr_sel && !rd_sel)); // R9

endmodule

// File: rtl/a10_hold_ctrl.sv
module a10_hold_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic read_grant,
    input  logic tx_loaded,
    input  logic hold_release,
    output logic hold_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_req <= 1'b0;
        end else if (read_grant) begin
            hold_req <= 1'b1;
        end else if (tx_loaded || hold_release) begin
            hold_req <= 1'b0;
        end
    end

    AST_HOLD_DROPS: assert property (@(posedge clk) disable iff (rst)
        (hold_req && (tx_loaded || hold_release) && !read_grant) |=> !hold_req); // R8
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (hold_req && !tx_loaded && !hold_release) |=> hold_req); // R8

endmodule

// File: rtl/addr10_tracker.sv
module addr10_tracker
    import a10_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_BITS-1:0] own_addr,
    input  logic                 start_pulse,
    input  logic                 stop_pulse,
    input  logic                 byte_valid,
    input  logic                 byte_first,
    input  logic [BYTE_BITS-1:0] byte_data,
    input  logic                 tx_loaded,
    input  logic                 hold_release,
    output logic                 addr_ack,
    output logic                 wr_sel,
    output logic                 rd_sel,
    output logic                 hold_req
);

    hi_info_t hi;
    logic     lo_eq;
    logic     read_grant;

    a10_hi_decode u_hi (
        .byte_data (byte_data),
        .own_upper (own_addr[ADDR_BITS-1:BYTE_BITS]),
        .info      (hi)
    );

    a10_lo_compare u_lo (
        .byte_data (byte_data),
        .own_lower (own_addr[BYTE_BITS-1:0]),
        .lo_eq     (lo_eq)
    );

    a10_match_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse),
        .byte_valid  (byte_valid),
        .byte_first  (byte_first),
        .hi          (hi),
        .lo_eq       (lo_eq),
        .addr_ack    (addr_ack),
        .wr_sel      (wr_sel),
        .rd_sel      (rd_sel),
        .read_grant  (read_grant)
    );

    a10_hold_ctrl u_hold (
        .clk          (clk),
        .rst          (rst),
        .read_grant   (read_grant),
        .tx_loaded    (tx_loaded),
        .hold_release (hold_release),
        .hold_req     (hold_req)
    );

    AST_HOLD_WITH_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_sel) |-> hold_req); // R7
    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(wr_sel && rd_sel)); // R9

endmodule

// File: tb/sim_addr10_tracker.sv
`timescale 1ns/1ps
module sim_addr10_tracker;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] own_addr = '0;
    logic       start_pulse = 1'b0, stop_pulse = 1'b0;
    logic       byte_valid = 1'b0, byte_first = 1'b0;
    logic [7:0] byte_data = '0;
    logic       tx_loaded = 1'b0, hold_release = 1'b0;
    logic       addr_ack, wr_sel, rd_sel, hold_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    addr10_tracker u0 (
        .clk(clk), .rst(rst), .own_addr(own_addr),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse),
        .byte_valid(byte_valid), .byte_first(byte_first), .byte_data(byte_data),
        .tx_loaded(tx_loaded), .hold_release(hold_release),
        .addr_ack(addr_ack), .wr_sel(wr_sel), .rd_sel(rd_sel), .hold_req(hold_req)
    );

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // One-cycle stimulus from a falling edge; returns at the next falling edge.
    task automatic step(input logic st, input logic sp, input logic bv,
                        input logic bf, input logic [7:0] bd,
                        input logic tx, input logic rel);
        @(negedge clk);
        start_pulse = st; stop_pulse = sp; byte_valid = bv;
        byte_first = bf; byte_data = bd; tx_loaded = tx; hold_release = rel;
        @(negedge clk);
        start_pulse = 0; stop_pulse = 0; byte_valid = 0;
        byte_first = 0; tx_loaded = 0; hold_release = 0;
    endtask

    task automatic do_start();           step(1, 0, 0, 0, 8'h00, 0, 0); endtask
    task automatic do_stop();            step(0, 1, 0, 0, 8'h00, 0, 0); endtask
    task automatic do_release();         step(0, 0, 0, 0, 8'h00, 0, 1); endtask
    task automatic send(input logic first, input logic [7:0] b); step(0, 0, 1, first, b, 0, 0); endtask

    function automatic logic [7:0] hi_byte(input logic [9:0] a, input logic rd);
        return {5'b11110, a[9:8], rd};
    endfunction

    task automatic full_write(input logic [9:0] a);
        do_start();
        send(1, hi_byte(a, 0));
        send(0, a[7:0]);
    endtask

    // Reads the remembered-match bit through a repeated Start and a read leading byte.
    task automatic probe(input string req, input logic exp, input string what);
        do_start();
        send(1, hi_byte(own_addr, 1));
        chk(req, addr_ack, exp, what);
        do_release();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [9:0] addrs [4];
        addrs[0] = 10'h2A5; addrs[1] = 10'h13C; addrs[2] = 10'h3FF; addrs[3] = 10'h000;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", addr_ack, 0, "ack in reset");
        chk("R1", wr_sel,   0, "wr_sel in reset");
        chk("R1", rd_sel,   0, "rd_sel in reset");
        chk("R1", hold_req, 0, "hold_req in reset");
        rst = 1'b0;
        own_addr = addrs[0];
        @(negedge clk);
        probe("R1", 0, "prior clear after reset");

        for (int k = 0; k < 4; k++) begin
            own_addr = addrs[k];
            do_stop();

            // R2 R6 R7: every leading byte value, remembered-match bit set first
            for (int hb = 0; hb < 256; hb++) begin
                logic [7:0] b;
                logic       m;
                b = hb[7:0];
                m = (b[7:3] == 5'b11110) && (b[2:1] == own_addr[9:8]);
                full_write(own_addr);
                chk("R4", wr_sel, 1, "write select after full match");
                do_start();
                send(1, b);
                chk("R2", addr_ack, m, "leading byte ack");
                chk("R7", rd_sel, m & b[0], "read select");
                chk("R7", hold_req, m & b[0], "hold request");
                do_release();
                probe("R6", m & b[0], "remembered bit after leading byte");
                do_stop();
            end

            // R3 R4: every trailing byte value, no remembered match
            for (int lb = 0; lb < 256; lb++) begin
                logic [7:0] b;
                b = lb[7:0];
                do_start();
                send(1, hi_byte(own_addr, 0));
                chk("R3", addr_ack, 1, "write leading byte ack");
                send(0, b);
                chk("R4", addr_ack, b == own_addr[7:0], "trailing byte ack");
                chk("R4", wr_sel,   b == own_addr[7:0], "write select");
                do_stop();
            end
        end

        own_addr = addrs[1];
        // R7 read without remembered match
        do_stop();
        do_start();
        send(1, hi_byte(own_addr, 1));
        chk("R7", addr_ack, 0, "read without prior ack");
        chk("R7", rd_sel,   0, "read without prior select");
        chk("R7", hold_req, 0, "read without prior hold");

        // R5 Stop clears
        full_write(own_addr);
        do_stop();
        chk("R5", wr_sel, 0, "wr_sel after stop");
        probe("R5", 0, "remembered bit after stop");

        // R8 R10 hold behaviour and ignored data bytes
        do_stop();
        full_write(own_addr);
        do_start();
        send(1, hi_byte(own_addr, 1));
        chk("R8", hold_req, 1, "hold raised");
        repeat (5) @(negedge clk);
        chk("R8", hold_req, 1, "hold kept while idle");
        send(0, hi_byte(own_addr, 0));
        chk("R10", addr_ack, 0, "data byte ignored");
        chk("R10", hold_req, 1, "hold unchanged by data byte");
        chk("R10", rd_sel,   1, "rd_sel unchanged by data byte");
        step(0, 0, 0, 0, 8'h00, 1, 0);
        chk("R8", hold_req, 0, "hold dropped by tx_loaded");
        chk("R8", rd_sel,   1, "rd_sel kept after tx_loaded");

        // R9 Start clears selects, keeps remembered bit; priority over byte strobe
        do_stop();
        full_write(own_addr);
        do_start();
        chk("R9", wr_sel, 0, "wr_sel after restart");
        probe("R9", 1, "remembered bit kept over restart");
        do_stop();
        step(0, 1, 1, 1, hi_byte(own_addr, 0), 0, 0);
        chk("R9", addr_ack, 0, "byte with stop ignored");
        step(1, 0, 1, 1, hi_byte(own_addr, 0), 0, 0);
        chk("R9", addr_ack, 0, "byte with start ignored");
        send(0, own_addr[7:0]);
        chk("R10", addr_ack, 0, "trailing byte without leading ignored");
        chk("R10", wr_sel,   0, "no write select without leading");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule